// File: doc/BRIEF.md
# Infrared Remote Carrier Generator

This peripheral builds an infrared remote-control carrier from a fast oscillator clock and gates it onto a single output pin. A base time unit (the tick) is derived by dividing the fast clock by 12, 16, 20 or 32. A carrier wave of period 8 or 12 fast-clock cycles, with one of four duty ratios, is switched onto the pin for a burst of one to three ticks. A separate countdown, also counted in ticks, raises an interrupt flag when it runs out.

A CPU drives the block through a small 4-bit register bus with write strobe, read strobe and a 3-bit address. A forced-output bit holds the pin high for software-timed signalling. A carrier enable bit removes the carrier from the pin without touching the burst timer. The interrupt flag clears when it is read. An enable bit decides whether the flag reaches the interrupt request line.

Top module: `irCarrierGen`

## Requirements
- R1: After reset `irOut` and `irqOut` are 0, address 1 reads 4'b0001 (carrier enabled, force off, interrupt masked) and address 0 reads 0.
- R2: Address 0 bits [1:0] select the tick divisor: code 0 gives 12, 1 gives 16, 2 gives 20 and 3 gives 32 fast-clock cycles per tick.
- R3: Address 0 bits [3:2] select the carrier. 00 gives period 8 with high time 2, 01 gives period 8 with high time 3, 10 gives period 12 with high time 4, and 11 gives period 12 with high time 3. Each period starts with its high phase.
- R4: Writing a nonzero value D to address 2 bits [1:0] restarts the tick divider and the carrier phase. The carrier then appears on `irOut` for exactly D×divisor cycles, starting in the cycle after the write.
- R5: Writing 0 to address 2 closes the gate, so `irOut` is low from the next cycle unless forced.
- R6: With the carrier enable (address 1 bit 0) at 0 and force off, `irOut` stays low even during a burst.
- R7: With the force bit (address 1 bit 1) at 1, `irOut` is high in every cycle.
- R8: Writing N to address 3 restarts the tick divider. The interrupt flag then sets exactly (N+1)×divisor cycles after the write and holds until it is read.
- R9: Address 4 bit 0 reads the interrupt flag. A read of address 4 clears the flag from the next cycle, so a second read returns 0.
- R10: `irqOut` is the flag gated by the interrupt enable (address 1 bit 2). While the enable is 0, `irqOut` stays low when the flag sets.
- R11: Address 3 is write-only and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears flag on status read) |
| addr | input | 3 | Register address |
| wrData | input | 4 | Write data |
| rdData | output | 4 | Read data, valid in the cycle of the read |
| irOut | output | 1 | Remote carrier output pin |
| irqOut | output | 1 | Interrupt request |

## Verification
Bursts use random pairs of tick divisor and carrier code with random lengths. Each burst is compared cycle by cycle against a model, and this separates a wrong divisor (burst length) from a wrong period or duty (pulse pattern). Directed bursts with the carrier disabled, the force bit set, and a burst cut short by a zero write separate gating faults from waveform faults. Interrupt countdowns at 0, 14 and random values, with the enable on and off, pin down the cycle the flag rises, its read-clear and its masking.

// File: rtl/irPkg.sv
package irPkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUR  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_ICNT = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

  typedef struct packed {
    logic              restart;
    logic              loadGate;
    logic [1:0]        gateVal;
    logic              loadIrq;
    logic [DATA_W-1:0] irqVal;
    logic              clearFlag;
  } irStrobes_t;

  function automatic logic [5:0] tauDiv(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd12;
      2'd1:    return 6'd16;
      2'd2:    return 6'd20;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [3:0] carPeriod(input logic [1:0] sel);
    return sel[1] ? 4'd12 : 4'd8;
  endfunction

  function automatic logic [3:0] carHigh(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd2;
      2'd1:    return 4'd3;
      2'd2:    return 4'd4;
      default: return 4'd3;
    endcase
  endfunction
endpackage

// File: rtl/irCtrl.sv
module irCtrl
  import irPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flag,
  output logic [DATA_W-1:0] rdData,
  output irStrobes_t        strobes,
  output logic [1:0]        tauSel,
  output logic [1:0]        carSel,
  output logic              carrierEn,
  output logic              forceOut,
  output logic              irqMask
);
  logic [DATA_W-1:0] cfgReg;
  logic [2:0]        ctlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
      ctlReg <= 3'b001;
    end else if (wrEn) begin
      if (addr == ADDR_CFG) cfgReg <= wrData;
      if (addr == ADDR_CTL) ctlReg <= wrData[2:0];
    end
  end

  assign tauSel    = cfgReg[1:0];
  assign carSel    = cfgReg[3:2];
  assign carrierEn = ctlReg[0];
  assign forceOut  = ctlReg[1];
  assign irqMask   = ctlReg[2];

  always_comb begin
    strobes.restart   = wrEn && (addr == ADDR_CFG || addr == ADDR_DUR || addr == ADDR_ICNT);
    strobes.loadGate  = wrEn && (addr == ADDR_DUR);
    strobes.gateVal   = wrData[1:0];
    strobes.loadIrq   = wrEn && (addr == ADDR_ICNT);
    strobes.irqVal    = wrData;
    strobes.clearFlag = rdEn && (addr == ADDR_STAT);
  end

  always_comb begin
    case (addr)
      ADDR_CFG:  rdData = cfgReg;
      ADDR_CTL:  rdData = {1'b0, ctlReg};
      ADDR_STAT: rdData = {3'b000, flag};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irDatapath.sv
module irDatapath
  import irPkg::*;
#(
  parameter int TAU_W = 6,
  parameter int CAR_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  irStrobes_t strobes,
  input  logic [1:0] tauSel,
  input  logic [1:0] carSel,
  input  logic       carrierEn,
  input  logic       forceOut,
  output logic       irOut,
  output logic       flag,
  output logic       irqFire
);
  logic [TAU_W-1:0]  tauCnt;
  logic [CAR_W-1:0]  carCnt;
  logic [1:0]        gateCnt;
  logic [DATA_W-1:0] irqCnt;
  logic              irqArmed;
  logic              tauLast;
  logic              tick;
  logic              carLast;
  logic              carWave;

  assign tauLast = (tauCnt == TAU_W'(tauDiv(tauSel) - 6'd1));
  assign tick    = tauLast && !strobes.restart;
  assign carLast = (carCnt >= CAR_W'(carPeriod(carSel) - 4'd1));
  assign carWave = (carCnt < CAR_W'(carHigh(carSel)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tauCnt <= '0;
      carCnt <= '0;
    end else if (strobes.restart) begin
      tauCnt <= '0;
      carCnt <= '0;
    end else begin
      tauCnt <= tauLast ? '0 : tauCnt + 1'b1;
      carCnt <= carLast ? '0 : carCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) gateCnt <= '0;
    else if (strobes.loadGate) gateCnt <= strobes.gateVal;
    else if (tick && gateCnt != 2'd0) gateCnt <= gateCnt - 2'd1;
  end

  assign irqFire = tick && irqArmed && (irqCnt == '0) && !strobes.loadIrq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqCnt   <= '0;
      irqArmed <= 1'b0;
    end else if (strobes.loadIrq) begin
      irqCnt   <= strobes.irqVal;
      irqArmed <= 1'b1;
    end else if (tick && irqArmed) begin
      if (irqCnt == '0) irqArmed <= 1'b0;
      else              irqCnt   <= irqCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  flag <= 1'b0;
    else if (irqFire)           flag <= 1'b1;
    else if (strobes.clearFlag) flag <= 1'b0;
  end

  assign irOut = forceOut | (carrierEn & (gateCnt != 2'd0) & carWave);
endmodule

// File: rtl/irCarrierGen.sv
module irCarrierGen
  import irPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [3:0]  wrData,
  output logic [3:0]  rdData,
  output logic        irOut,
  output logic        irqOut
);
  irStrobes_t strobes;
  logic [1:0] tauSel;
  logic [1:0] carSel;
  logic       carrierEn;
  logic       forceOut;
  logic       irqMask;
  logic       flag;
  logic       irqFire;

  irCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .flag(flag), .rdData(rdData), .strobes(strobes),
    .tauSel(tauSel), .carSel(carSel), .carrierEn(carrierEn),
    .forceOut(forceOut), .irqMask(irqMask)
  );

  irDatapath #(.TAU_W(6), .CAR_W(4)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tauSel(tauSel),
    .carSel(carSel), .carrierEn(carrierEn), .forceOut(forceOut),
    .irOut(irOut), .flag(flag), .irqFire(irqFire)
  );

  assign irqOut = flag & irqMask;
endmodule

// File: rtl/irCarrierGen_chk.sv
module irCarrierGen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [2:0] addr,
  input logic [3:0] wrData,
  input logic       irOut,
  input logic       irqOut,
  input logic       forceOut,
  input logic       carrierEn,
  input logic       irqMask,
  input logic       flag,
  input logic       irqFire
);
  assert_force_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    forceOut |-> irOut);

  assert_disabled_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!carrierEn && !forceOut) |-> !irOut);

  assert_gate_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2 && wrData[1:0] == 2'd0) |=> (irOut == forceOut));

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(rdEn && addr == 3'd4)) |=> flag);

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd4 && !irqFire) |=> !flag);

  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irqMask |-> !irqOut);
endmodule

bind irCarrierGen irCarrierGen_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .irOut(irOut), .irqOut(irqOut), .forceOut(forceOut),
  .carrierEn(carrierEn), .irqMask(irqMask), .flag(flag), .irqFire(irqFire)
);

// File: tb/irCarrierGen_bench.sv
`timescale 1ns/1ps
module irCarrierGen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wrData = '0;
  logic [3:0] rdData;
  logic       irOut;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irCarrierGen u_irCarrierGen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irOut(irOut), .irqOut(irqOut)
  );

  function automatic int expDiv(input int t);
    case (t) 0: return 12; 1: return 16; 2: return 20; default: return 32; endcase
  endfunction
  function automatic int expPer(input int c);
    return (c >= 2) ? 12 : 8;
  endfunction
  function automatic int expHigh(input int c);
    case (c) 0: return 2; 1: return 3; 2: return 4; default: return 3; endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Burst of length D ticks; compares irOut each cycle (R2, R3, R4, R6)
  task automatic burst(input int t, input int c, input bit en, input int d, input string req);
    int errs = 0;
    int firstBad = -1;
    int len;
    wr(3'd0, 4'((c << 2) | t));
    wr(3'd1, {3'b000, en});
    wr(3'd2, 4'(d));
    len = d * expDiv(t);
    for (int k = 0; k < len + 3 * expPer(c); k++) begin
      bit e;
      e = en && (k < len) && ((k % expPer(c)) < expHigh(c));
      if (irOut !== e) begin
        errs++;
        if (firstBad < 0) firstBad = k;
      end
      @(negedge clk);
    end
    check(errs == 0, req, firstBad, -1);
  endtask

  // Interrupt countdown: flag timing, masking, read-clear (R8, R9, R10)
  task automatic irqRun(input int t, input int n, input bit mask);
    logic [3:0] v;
    int fireAt;
    wr(3'd0, 4'(t));
    wr(3'd1, {1'b0, mask, 2'b01});
    wr(3'd3, 4'(n));
    fireAt = (n + 1) * expDiv(t);
    for (int m = 0; m <= fireAt; m++) begin
      if (m == fireAt - 1) check(irqOut === 1'b0, "R8 early", irqOut, 0);
      if (m == fireAt)     check(irqOut === mask, "R10 irq at fire", irqOut, mask);
      if (m < fireAt) @(negedge clk);
    end
    rd(3'd4, v);
    check(v[0] === 1'b1, "R9 flag read", v[0], 1);
    rd(3'd4, v);
    check(v[0] === 1'b0, "R9 flag cleared", v[0], 0);
    check(irqOut === 1'b0, "R10 irq after clear", irqOut, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irOut === 1'b0, "R1 irOut", irOut, 0);
    check(irqOut === 1'b0, "R1 irqOut", irqOut, 0);
    rd(3'd1, v); check(v === 4'b0001, "R1 ctl", v, 1);
    rd(3'd0, v); check(v === 4'b0000, "R1 cfg", v, 0);
    // R11 write-only counter reads zero
    wr(3'd3, 4'hA);
    rd(3'd3, v); check(v === 4'b0000, "R11 readback", v, 0);
    wr(3'd3, 4'h0);
    repeat (40) @(negedge clk);
    rd(3'd4, v);

    // R3 all carrier codes, R2 all divisors
    for (int c = 0; c < 4; c++) burst(c, c, 1'b1, 1, "R3 carrier code");
    for (int t = 0; t < 4; t++) burst(t, 0, 1'b1, 3, "R2 divisor");
    // R4 random bursts
    for (int i = 0; i < 12; i++)
      burst($urandom % 4, $urandom % 4, 1'b1, 1 + ($urandom % 3), "R4 random burst");
    // R6 carrier disabled
    burst(1, 2, 1'b0, 3, "R6 disabled");

    // R5 cut burst short
    wr(3'd0, 4'b0000);
    wr(3'd1, 4'b0001);
    wr(3'd2, 4'd3);
    repeat (5) @(negedge clk);
    wr(3'd2, 4'd0);
    begin
      int hi = 0;
      for (int k = 0; k < 60; k++) begin
        if (irOut !== 1'b0) hi++;
        @(negedge clk);
      end
      check(hi == 0, "R5 gate closed", hi, 0);
    end

    // R7 force
    wr(3'd1, 4'b0011);
    begin
      int lo = 0;
      for (int k = 0; k < 40; k++) begin
        if (irOut !== 1'b1) lo++;
        @(negedge clk);
      end
      check(lo == 0, "R7 forced high", lo, 0);
    end
    wr(3'd1, 4'b0001);
    @(negedge clk);
    check(irOut === 1'b0, "R7 force released", irOut, 0);

    // R8/R9/R10 interrupt
    irqRun(0, 0, 1'b1);
    irqRun(3, 14, 1'b1);
    irqRun(2, 0, 1'b0);
    for (int i = 0; i < 4; i++) irqRun($urandom % 4, $urandom % 15, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule